// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers up to 32 interrupt event lines into one pending register. It qualifies that register with a software enable mask and raises a single registered interrupt request toward the processor. Each event line is sampled on every clock. A high level, or a one-cycle pulse, latches the matching pending bit, and the bit stays set until software clears it. The raw pending value can always be read, so a driver can poll a device whose interrupt is disabled. A second view returns only the pending bits that are also enabled, and a service routine reads it to find what needs attention.

Software reaches three word registers over a simple single-cycle register bus. The pending register is cleared by writing ones. The enabled-pending view is written to inject interrupts for test. The enable register is plain read/write. By default the bit assignment is as follows. Bits 9..0 are external pins. Bits 15..10 and 21..16 are the flag groups of two serial ports. Bit 22 flags a write-protection violation and bit 23 a read-protection violation. Bit 30 is an uncorrectable memory error and bit 31 a corrected memory error. Bits 29..24 are not implemented.

Top module: `irq_status_ctrl`

## Requirements
- R1: A write to word address 2 (mask) stores the written enable bits. A read of address 2 returns them.
- R2: A read of word address 0 (status) returns every pending bit regardless of the mask.
- R3: A high level on src_i[b] sets pending bit b at that clock edge. The bit stays set after the source drops until it is cleared.
- R4: A write to address 0 clears each pending bit written as one. Bits written as zero keep their value.
- R5: When a source event and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R6: A read of word address 1 (cause) returns the pending bits ANDed with the mask.
- R7: A write to address 1 sets each pending bit written as one, and leaves the other bits as they were.
- R8: irq_o is a register that, on each edge, takes the OR of all bits of (pending AND mask) as they stood before that edge.
- R9: Bits 29..24 always read as zero in status, cause and mask. Writes and source events have no effect on them. Address 3 reads as zero.
- R10: After reset, pending and mask are all zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt event lines, active high |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word address: 0 status, 1 cause, 2 mask |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A pending or mask bit in the wrong state appears at rdata_o in the same cycle the register is read, because read data is combinational from the current state. The same wrong bit changes irq_o on the very next edge whenever the other operand of the AND is set. The bench mirrors both registers and reads them back often, so a lost clear, a missed event or a stuck reserved bit is reported within a few cycles of the cause. Same-cycle collisions between events and clears are driven on purpose, as well as at random.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_STATUS = 0;
  localparam int unsigned REG_CAUSE  = 1;
  localparam int unsigned REG_MASK   = 2;

  // implemented bits: 31..30 and 23..0
  localparam logic [31:0] IMPL_DEFAULT = 32'hC0FF_FFFF;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 2
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] mask_i,
  output logic          clr_we_o,
  output logic          set_we_o,
  output logic          mask_we_o,
  output logic [DW-1:0] rdata_o
);
  import irq_pkg::*;

  localparam logic [AW-1:0] A_STATUS = AW'(REG_STATUS);
  localparam logic [AW-1:0] A_CAUSE  = AW'(REG_CAUSE);
  localparam logic [AW-1:0] A_MASK   = AW'(REG_MASK);

  logic wr;
  assign wr = req_i & we_i;

  assign clr_we_o  = wr & (addr_i == A_STATUS);
  assign set_we_o  = wr & (addr_i == A_CAUSE);
  assign mask_we_o = wr & (addr_i == A_MASK);

  always_comb begin
    unique case (addr_i)
      A_STATUS: rdata_o = status_i;
      A_CAUSE:  rdata_o = status_i & mask_i;
      A_MASK:   rdata_o = mask_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits #(
  parameter int unsigned DW        = 32,
  parameter logic [DW-1:0] IMPL_MASK = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] clr_i,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] status_o
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_impl
      logic q;
      // event and software set dominate a same-cycle clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= src_i[b] | set_i[b] | (q & ~clr_i[b]);
      end
      assign status_o[b] = q;
    end else begin : g_rsvd
      assign status_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_req_reg.sv
module irq_req_reg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] cause_i,
  output logic          irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |cause_i;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int unsigned   DW        = 32,
  parameter int unsigned   AW        = 2,
  parameter logic [DW-1:0] IMPL_MASK = irq_pkg::IMPL_DEFAULT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] src_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic          clr_we, set_we, mask_we;
  logic [DW-1:0] status_q, mask_q;
  logic [DW-1:0] clr_vec, set_vec;

  irq_bus_decode #(.DW(DW), .AW(AW)) u_dec (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .status_i  (status_q),
    .mask_i    (mask_q),
    .clr_we_o  (clr_we),
    .set_we_o  (set_we),
    .mask_we_o (mask_we),
    .rdata_o   (rdata_o)
  );

  assign clr_vec = clr_we ? wdata_i : '0;
  assign set_vec = set_we ? wdata_i : '0;

  irq_status_bits #(.DW(DW), .IMPL_MASK(IMPL_MASK)) u_bits (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .clr_i    (clr_vec),
    .set_i    (set_vec),
    .status_o (status_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_we) mask_q <= wdata_i & IMPL_MASK;
  end

  irq_req_reg #(.DW(DW)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cause_i (status_q & mask_q),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int unsigned   DW        = 32,
  parameter int unsigned   AW        = 2,
  parameter logic [DW-1:0] IMPL_MASK = irq_pkg::IMPL_DEFAULT
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] src_i,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          irq_o,
  input logic [DW-1:0] status_q,
  input logic [DW-1:0] mask_q
);
  logic wr_status, wr_cause, wr_mask;
  assign wr_status = req_i && we_i && (addr_i == AW'(irq_pkg::REG_STATUS));
  assign wr_cause  = req_i && we_i && (addr_i == AW'(irq_pkg::REG_CAUSE));
  assign wr_mask   = req_i && we_i && (addr_i == AW'(irq_pkg::REG_MASK));

  assert_mask_store_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> mask_q == ($past(wdata_i) & IMPL_MASK));

  assert_event_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(src_i) & IMPL_MASK) == ($past(src_i) & IMPL_MASK)));

  assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_status |=> ((status_q & $past(wdata_i) & ~$past(src_i)) == '0));

  assert_event_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status && ((src_i & wdata_i & IMPL_MASK) != '0))
      |=> ((status_q & $past(src_i & wdata_i) & IMPL_MASK) == ($past(src_i & wdata_i) & IMPL_MASK)));

  assert_cause_view_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(irq_pkg::REG_CAUSE)) |-> rdata_o == (status_q & mask_q));

  assert_inject_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cause |=> ((status_q & $past(wdata_i) & IMPL_MASK) == ($past(wdata_i) & IMPL_MASK)));

  assert_irq_reg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(status_q & mask_q)));

  assert_rsvd_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o & ~IMPL_MASK) == '0) && ((status_q & ~IMPL_MASK) == '0));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.DW(DW), .AW(AW), .IMPL_MASK(IMPL_MASK)) u_chk (.*);

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
  localparam logic [31:0] IMPL = 32'hC0FF_FFFF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] st_m = '0;
  logic [31:0] mk_m = '0;
  logic        irq_m = 1'b0;

  irq_status_ctrl uut (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return st_m;
      2'd1:    return st_m & mk_m;
      2'd2:    return mk_m;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(input logic [1:0] a);
    case (a)
      2'd0:    return "R2";
      2'd1:    return "R6";
      2'd2:    return "R1";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // one bus cycle; inputs applied after negedge, read checked before edge, irq after edge
  task automatic step(input logic [31:0] src, input bit rq, input bit w,
                      input logic [1:0] a, input logic [31:0] wd, input string tag);
    src_i = src; req_i = rq; we_i = w; addr_i = a; wdata_i = wd;
    #1;
    if (rq && !w) chk(rdata_o === exp_read(a), tag, rdata_o, exp_read(a));
    @(posedge clk_i);
    irq_m = |(st_m & mk_m);
    st_m = ((st_m & ~((rq && w && a == 2'd0) ? wd : 32'h0))
            | src | ((rq && w && a == 2'd1) ? wd : 32'h0)) & IMPL;
    if (rq && w && a == 2'd2) mk_m = wd & IMPL;
    @(negedge clk_i);
    chk(irq_o === irq_m, "R8", {31'h0, irq_o}, {31'h0, irq_m});
  endtask

  task automatic rd_lit(input logic [1:0] a, input logic [31:0] lit, input string tag);
    src_i = '0; req_i = 1'b1; we_i = 1'b0; addr_i = a; wdata_i = '0;
    #1;
    chk(rdata_o === lit, tag, rdata_o, lit);
    step(32'h0, 1'b1, 1'b0, a, 32'h0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10: reset state
    chk(irq_o === 1'b0, "R10", {31'h0, irq_o}, 32'h0);
    rd_lit(2'd0, 32'h0, "R10");
    rd_lit(2'd2, 32'h0, "R10");
    // R1 / R9: mask store with reserved bits dropped
    step(32'h0, 1'b1, 1'b1, 2'd2, 32'hFFFF_FFFF, "R1");
    rd_lit(2'd2, 32'hC0FF_FFFF, "R1");
    rd_lit(2'd3, 32'h0, "R9");
    // R3: pulse latches and is sticky
    step(32'h0000_0008, 1'b0, 1'b0, 2'd0, 32'h0, "R3");
    rd_lit(2'd0, 32'h0000_0008, "R3");
    rd_lit(2'd0, 32'h0000_0008, "R3");
    chk(irq_o === 1'b1, "R8", {31'h0, irq_o}, 32'h1);
    // R4: zeros keep, ones clear
    step(32'h0, 1'b1, 1'b1, 2'd0, 32'h0000_0000, "R4");
    rd_lit(2'd0, 32'h0000_0008, "R4");
    step(32'h0, 1'b1, 1'b1, 2'd0, 32'h0000_0008, "R4");
    rd_lit(2'd0, 32'h0, "R4");
    // R5: collision, event wins
    step(32'h8000_0000, 1'b1, 1'b1, 2'd0, 32'h8000_0000, "R5");
    rd_lit(2'd0, 32'h8000_0000, "R5");
    step(32'h0, 1'b1, 1'b1, 2'd0, 32'hFFFF_FFFF, "R4");
    // R7 / R6: inject and masked view
    step(32'h0, 1'b1, 1'b1, 2'd2, 32'h0000_0001, "R1");
    step(32'h0, 1'b1, 1'b1, 2'd1, 32'h0000_0003, "R7");
    rd_lit(2'd0, 32'h0000_0003, "R7");
    rd_lit(2'd1, 32'h0000_0001, "R6");
    // R9: reserved bits ignore inject and sources
    step(32'h0, 1'b1, 1'b1, 2'd1, 32'h3F00_0000, "R9");
    step(32'h3F00_0000, 1'b0, 1'b0, 2'd0, 32'h0, "R9");
    rd_lit(2'd0, 32'h0000_0003, "R9");
    // R8 / R2: mask off drops irq, status still visible
    step(32'h0, 1'b1, 1'b1, 2'd2, 32'h0, "R8");
    step(32'h0, 1'b0, 1'b0, 2'd0, 32'h0, "R8");
    chk(irq_o === 1'b0, "R8", {31'h0, irq_o}, 32'h0);
    rd_lit(2'd0, 32'h0000_0003, "R2");
    rd_lit(2'd1, 32'h0, "R6");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] s, wd;
      logic [1:0]  a;
      bit          rq, w;
      s  = $urandom & $urandom & $urandom;
      if ($urandom % 3 == 0) s = '0;
      rq = ($urandom % 4) != 0;
      w  = ($urandom % 3) == 0;
      a  = 2'($urandom);
      wd = $urandom;
      step(s, rq, w, a, wd, read_tag(a));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule